// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits on the controller side of an SDRAM interface and follows every command the controller drives onto the device pins. It keeps, for each bank, a record of whether the bank is idle, open, closing itself after an auto-precharge, or recovering from a precharge. From that record it reports whether the command on the pins in the current cycle is allowed. All timing limits are clock-cycle counts given as parameters: minimum open time, maximum open time, precharge recovery, refresh cycle time and write recovery. Burst length and CAS latency arrive on configuration inputs.

The command-check output is combinational on the current pins and the tracked state, so a controller can gate its issue decision in the same cycle. A command that is flagged illegal leaves the tracked state untouched. Each bank has its own warning output that rises a configurable number of cycles before that bank's maximum open time runs out. An all-idle output tells the scheduler when refresh, mode programming or a low-power entry may go out.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset every bank reads idle, `allIdle` is high, and `bankActive` and `mustPrecharge` are all zero.
- R2: Command pins `{csN,rasN,casN,weN}` decode as 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode set, 0111 no-op, and csN high means deselect. An activate is legal only to an idle bank and opens it from the next cycle. Any illegal command leaves every bank's state unchanged.
- R3: A single-bank precharge (apFlag low) to an open bank is legal only when at least T_RAS_MIN cycles have passed since its activate. The bank then reads idle again T_RP cycles after the precharge.
- R4: A precharge with apFlag high covers every bank. It is legal only if no bank is auto-precharging and every open bank has met T_RAS_MIN, and all banks are idle T_RP cycles later.
- R5: Reads and writes are legal only to an open bank. With apFlag low the bank stays open.
- R6: A read or write with apFlag high starts an internal precharge at cycle max(cmd + BL + CL, act + T_RAS_MIN) for a read, or max(cmd + BL + T_WR, act + T_RAS_MIN) for a write. The bank is idle T_RP cycles after that, and `bankActive` stays high until the internal precharge starts.
- R7: While a bank is auto-precharging, every activate, read, write or precharge addressed to it is illegal.
- R8: `mustPrecharge[b]` rises exactly T_RAS_MAX-1-T_WARN cycles after the activate of an open bank and falls when that bank is precharged.
- R9: Refresh and mode set are legal only when `allIdle` is high. After a refresh, `allIdle` is low for T_RC cycles and only no-op or deselect is legal.
- R10: A cycle with cke low after a cycle with cke high is a low-power entry. It is legal only with `allIdle` high and a no-op, deselect or refresh command. While cke was low in the previous cycle no command is decoded and `cmdLegal` is high. Leaving plain power-down adds no busy time.
- R11: A refresh with cke falling enters self refresh, and `allIdle` is low while in it. The first cycle with cke high ends it, after which `allIdle` stays low for T_RC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable pin as driven to the device |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | BA_W | Bank targeted by the command |
| apFlag | input | 1 | Auto-precharge / all-banks address bit |
| cfgBurstLen | input | BL_W | Programmed burst length in cycles (1 or more) |
| cfgCasLat | input | CL_W | Programmed CAS latency in cycles (1 or more) |
| bankIdle | output | NUM_BANKS | Bank is idle and free to activate |
| bankActive | output | NUM_BANKS | Bank has an open row |
| mustPrecharge | output | NUM_BANKS | Bank is close to its maximum open time |
| allIdle | output | 1 | All banks idle and no refresh or self refresh in progress |
| cmdLegal | output | 1 | Command on the pins this cycle is allowed |

## Verification
The hardest case to reach is an auto-precharge where the bank's minimum open time, not the burst end, sets when the internal precharge begins. The stimulus reaches it by issuing the read with auto-precharge one cycle after the activate, with burst length and latency at 1. A write with latency 1 then shows that write recovery, not CAS latency, sets the delay. Self-refresh exit is reached by holding cke low across a refresh and then raising it while banks are idle, and the stimulus probes with an activate that the busy window must reject.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE, BK_OPEN, BK_AUTO, BK_PRE
  } bankState_e;

  // Strobes from the control to one bank's datapath
  typedef struct packed {
    logic act;
    logic pre;
    logic autoPre;
    logic autoRead;
  } bankStrobe_t;

endpackage

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BA_W      = 1,
  parameter int T_RC      = 6,
  localparam int RC_W     = $clog2(T_RC + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cke,
  input  logic                          csN,
  input  logic                          rasN,
  input  logic                          casN,
  input  logic                          weN,
  input  logic [BA_W-1:0]               bankAddr,
  input  logic                          apFlag,
  input  logic [NUM_BANKS-1:0]          stIdle,
  input  logic [NUM_BANKS-1:0]          stOpen,
  input  logic [NUM_BANKS-1:0]          stAuto,
  input  logic [NUM_BANKS-1:0]          stRasMet,
  output bankStrobe_t [NUM_BANKS-1:0]   strbVec,
  output logic                          banksHeld,
  output logic                          allIdle,
  output logic                          cmdLegal
);

  cmd_e                  cmd;
  logic                  prevCke, selfRef, rcActive;
  logic [RC_W-1:0]       rcLeft;
  logic [NUM_BANKS-1:0]  selHot;
  logic                  selIdle, selOpen, selAuto, selRasMet;
  logic                  preAllOk, preOneOk, doIt, rcLoad;

  always_comb begin
    if (csN) cmd = CMD_NOP;
    else begin
      unique case ({rasN, casN, weN})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign selHot    = NUM_BANKS'(1) << bankAddr;
  assign selIdle   = |(stIdle & selHot);
  assign selOpen   = |(stOpen & selHot);
  assign selAuto   = |(stAuto & selHot);
  assign selRasMet = |(stRasMet & selHot);

  assign banksHeld = rcActive | selfRef;
  assign allIdle   = (&stIdle) & ~banksHeld;

  assign preAllOk = !rcActive && !(|stAuto) && (&(~stOpen | stRasMet));
  assign preOneOk = !rcActive && !selAuto && (!selOpen || selRasMet);

  always_comb begin
    if (!prevCke)  cmdLegal = 1'b1;
    else if (!cke) cmdLegal = allIdle && (cmd == CMD_NOP || cmd == CMD_REF);
    else begin
      unique case (cmd)
        CMD_ACT:         cmdLegal = selIdle && !rcActive;
        CMD_RD, CMD_WR:  cmdLegal = selOpen;
        CMD_PRE:         cmdLegal = apFlag ? preAllOk : preOneOk;
        CMD_REF,
        CMD_MRS:         cmdLegal = allIdle;
        default:         cmdLegal = 1'b1;
      endcase
    end
  end

  assign doIt   = cmdLegal && prevCke && cke;
  assign rcLoad = (doIt && cmd == CMD_REF) || (selfRef && cke);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strb
    always_comb begin
      strbVec[b].act      = doIt && cmd == CMD_ACT && selHot[b];
      strbVec[b].pre      = doIt && cmd == CMD_PRE && (apFlag || selHot[b]);
      strbVec[b].autoPre  = doIt && (cmd == CMD_RD || cmd == CMD_WR) && apFlag && selHot[b];
      strbVec[b].autoRead = (cmd == CMD_RD);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCke  <= 1'b1;
      selfRef  <= 1'b0;
      rcActive <= 1'b0;
      rcLeft   <= '0;
    end else begin
      prevCke <= cke;
      if (prevCke && !cke && cmd == CMD_REF && cmdLegal) selfRef <= 1'b1;
      else if (selfRef && cke)                           selfRef <= 1'b0;
      if (rcLoad) begin
        rcActive <= 1'b1;
        rcLeft   <= RC_W'(T_RC - 1);
      end else if (rcActive) begin
        if (rcLeft == '0) rcActive <= 1'b0;
        else              rcLeft   <= rcLeft - 1'b1;
      end
    end
  end

  // R10: self refresh is only ever entered from an all-idle state
  p_selfref_from_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfRef) |-> $past(allIdle));

  // R11: leaving self refresh always starts the refresh busy window
  p_selfref_exit_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selfRef) |-> rcActive);

endmodule

// File: rtl/sdram_trk_bank.sv
module sdram_trk_bank
  import sdram_trk_pkg::*;
#(
  parameter int T_RAS_MIN = 4,
  parameter int T_RAS_MAX = 40,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int T_WARN    = 5,
  parameter int BL_W      = 4,
  parameter int CL_W      = 2,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankStrobe_t      strb,
  input  logic [BL_W-1:0]  cfgBurstLen,
  input  logic [CL_W-1:0]  cfgCasLat,
  output logic             isIdle,
  output logic             isOpen,
  output logic             isAuto,
  output logic             rasMet,
  output logic             mustPre
);

  bankState_e        state;
  logic [CNT_W-1:0]  minLeft, maxLeft, burstLeft, rpLeft, burstDelay;

  assign burstDelay = strb.autoRead ? CNT_W'(cfgBurstLen) + CNT_W'(cfgCasLat)
                                    : CNT_W'(cfgBurstLen) + CNT_W'(T_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= BK_IDLE;
      minLeft   <= '0;
      maxLeft   <= '0;
      burstLeft <= '0;
      rpLeft    <= '0;
    end else begin
      unique case (state)
        BK_IDLE: if (strb.act) begin
          state   <= BK_OPEN;
          minLeft <= CNT_W'(T_RAS_MIN - 1);
          maxLeft <= CNT_W'(T_RAS_MAX - 1);
        end
        BK_OPEN: begin
          if (minLeft != '0) minLeft <= minLeft - 1'b1;
          if (maxLeft != '0) maxLeft <= maxLeft - 1'b1;
          if (strb.pre) begin
            state  <= BK_PRE;
            rpLeft <= CNT_W'(T_RP - 1);
          end else if (strb.autoPre) begin
            state     <= BK_AUTO;
            burstLeft <= burstDelay - 1'b1;
          end
        end
        BK_AUTO: begin
          if (minLeft != '0)   minLeft   <= minLeft - 1'b1;
          if (burstLeft != '0) burstLeft <= burstLeft - 1'b1;
          if (minLeft == '0 && burstLeft == '0) begin
            state  <= BK_PRE;
            rpLeft <= CNT_W'(T_RP - 1);
          end
        end
        default: begin
          if (rpLeft == '0) state  <= BK_IDLE;
          else              rpLeft <= rpLeft - 1'b1;
        end
      endcase
    end
  end

  assign isIdle  = (state == BK_IDLE);
  assign isOpen  = (state == BK_OPEN);
  assign isAuto  = (state == BK_AUTO);
  assign rasMet  = (minLeft == '0);
  assign mustPre = isOpen && (maxLeft <= CNT_W'(T_WARN));

  // R2: the control only opens a bank that is idle
  p_act_only_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.act |-> state == BK_IDLE);

  // R3: a precharge to an open bank never cuts its minimum open time
  p_pre_after_min_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pre && state == BK_OPEN) |-> minLeft == '0);

  // R7: nothing reaches a bank that is closing itself
  p_auto_untouched_r7: assert property (@(posedge clk) disable iff (!rstN)
    state == BK_AUTO |-> !(strb.act || strb.pre || strb.autoPre));

  // R6: the internal precharge waits for the minimum open time
  p_auto_waits_min_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == BK_AUTO && minLeft != '0) |=> state == BK_AUTO);

  // R8: a precharge clears the deadline warning
  p_warn_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mustPre && strb.pre) |=> !mustPre);

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int T_RAS_MIN = 4,
  parameter int T_RAS_MAX = 40,
  parameter int T_RP      = 3,
  parameter int T_RC      = 6,
  parameter int T_WR      = 2,
  parameter int T_WARN    = 5,
  parameter int BL_W      = 4,
  parameter int CL_W      = 2,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W    = $clog2(T_RAS_MAX + (1 << BL_W) + (1 << CL_W) + T_WR + T_RP + 2)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cke,
  input  logic                  csN,
  input  logic                  rasN,
  input  logic                  casN,
  input  logic                  weN,
  input  logic [BA_W-1:0]       bankAddr,
  input  logic                  apFlag,
  input  logic [BL_W-1:0]       cfgBurstLen,
  input  logic [CL_W-1:0]       cfgCasLat,
  output logic [NUM_BANKS-1:0]  bankIdle,
  output logic [NUM_BANKS-1:0]  bankActive,
  output logic [NUM_BANKS-1:0]  mustPrecharge,
  output logic                  allIdle,
  output logic                  cmdLegal
);

  bankStrobe_t [NUM_BANKS-1:0] strbVec;
  logic [NUM_BANKS-1:0]        stIdle, stOpen, stAuto, stRasMet;
  logic                        banksHeld;

  sdram_trk_ctrl #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .T_RC(T_RC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .apFlag(apFlag),
    .stIdle(stIdle), .stOpen(stOpen), .stAuto(stAuto), .stRasMet(stRasMet),
    .strbVec(strbVec), .banksHeld(banksHeld), .allIdle(allIdle),
    .cmdLegal(cmdLegal)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_trk_bank #(
      .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP),
      .T_WR(T_WR), .T_WARN(T_WARN), .BL_W(BL_W), .CL_W(CL_W), .CNT_W(CNT_W)
    ) u_bank (
      .clk(clk), .rstN(rstN), .strb(strbVec[b]),
      .cfgBurstLen(cfgBurstLen), .cfgCasLat(cfgCasLat),
      .isIdle(stIdle[b]), .isOpen(stOpen[b]), .isAuto(stAuto[b]),
      .rasMet(stRasMet[b]), .mustPre(mustPrecharge[b])
    );
  end

  assign bankIdle   = stIdle & {NUM_BANKS{~banksHeld}};
  assign bankActive = stOpen | stAuto;

endmodule

// File: tb/sim_sdram_bank_tracker.sv
module sim_sdram_bank_tracker;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000, C_DES = 4'b1111;

  // {pins, bank, ap, expected legal}
  localparam logic [6:0] VEC [0:13] = '{
    {C_NOP, 1'b0, 1'b0, 1'b1},
    {C_ACT, 1'b0, 1'b0, 1'b1},
    {C_ACT, 1'b0, 1'b0, 1'b0},
    {C_RD,  1'b1, 1'b0, 1'b0},
    {C_PRE, 1'b0, 1'b0, 1'b0},
    {C_REF, 1'b0, 1'b0, 1'b0},
    {C_PRE, 1'b0, 1'b1, 1'b1},
    {C_ACT, 1'b0, 1'b0, 1'b0},
    {C_NOP, 1'b0, 1'b0, 1'b1},
    {C_ACT, 1'b1, 1'b0, 1'b1},
    {C_ACT, 1'b0, 1'b0, 1'b1},
    {C_MRS, 1'b0, 1'b0, 1'b0},
    {C_WR,  1'b1, 1'b0, 1'b1},
    {C_DES, 1'b0, 1'b0, 1'b1}
  };

  logic       clk = 1'b0, rstN = 1'b0, cke = 1'b1;
  logic       csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [0:0] bankAddr = '0;
  logic       apFlag = 1'b0;
  logic [3:0] cfgBurstLen = 4'd2;
  logic [1:0] cfgCasLat = 2'd2;
  logic [1:0] bankIdle, bankActive, mustPrecharge;
  logic       allIdle, cmdLegal;
  int         nRun = 0, nFail = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  sdram_bank_tracker u0 (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .apFlag(apFlag), .cfgBurstLen(cfgBurstLen),
    .cfgCasLat(cfgCasLat), .bankIdle(bankIdle), .bankActive(bankActive),
    .mustPrecharge(mustPrecharge), .allIdle(allIdle), .cmdLegal(cmdLegal)
  );

  function automatic string vecTag(int i);
    case (i)
      1, 2, 7, 9, 10: return "R2";
      3, 12:          return "R5";
      4:              return "R3";
      6:              return "R4";
      5, 11:          return "R9";
      default:        return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // One command, one clock edge; legality checked before the edge
  task automatic doCmd(input logic [3:0] pins, input logic bnk, input logic ap,
                       input logic ck, input logic expL, input string tag);
    @(negedge clk);
    {csN, rasN, casN, weN} = pins;
    bankAddr = bnk;
    apFlag   = ap;
    cke      = ck;
    #2;
    chk({tag, " cmdLegal"}, {31'd0, cmdLegal}, {31'd0, expL});
    @(posedge clk);
    #1;
    {csN, rasN, casN, weN} = C_DES;
    apFlag = 1'b0;
    cke    = 1'b1;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) doCmd(C_NOP, 1'b0, 1'b0, 1'b1, 1'b1, "R2 nop");
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 bankIdle", bankIdle, 2'b11);
    chk("R1 allIdle", allIdle, 1);
    chk("R1 bankActive", bankActive, 0);
    chk("R1 mustPrecharge", mustPrecharge, 0);

    for (int i = 0; i < 14; i++)
      doCmd(VEC[i][6:3], VEC[i][2], VEC[i][1], 1'b1, VEC[i][0], vecTag(i));

    doReset();
    chk("R1 bankIdle after second reset", bankIdle, 2'b11);

    // R3 single precharge timing
    doCmd(C_ACT, 0, 0, 1, 1, "R3 act");
    chk("R2 bank opens", bankActive, 2'b01);
    nop(2);
    doCmd(C_PRE, 0, 0, 1, 0, "R3 early pre");
    doCmd(C_PRE, 0, 0, 1, 1, "R3 pre at min");
    nop(2);
    chk("R3 still recovering", bankIdle[0], 0);
    nop(1);
    chk("R3 idle after tRP", bankIdle[0], 1);

    // R5 read without auto-precharge keeps bank open
    doCmd(C_ACT, 0, 0, 1, 1, "R5 act");
    nop(3);
    doCmd(C_RD, 0, 0, 1, 1, "R5 read");
    nop(3);
    chk("R5 stays open", bankActive[0], 1);
    doCmd(C_PRE, 0, 0, 1, 1, "R5 pre");
    nop(3);
    chk("R5 closed", bankIdle[0], 1);

    // R6 / R7 read with auto-precharge, burst end dominates
    doCmd(C_ACT, 1, 0, 1, 1, "R6 act");
    doCmd(C_RD, 1, 1, 1, 1, "R6 read ap");
    doCmd(C_ACT, 1, 0, 1, 0, "R7 act to closing bank");
    doCmd(C_PRE, 1, 0, 1, 0, "R7 pre to closing bank");
    doCmd(C_WR, 1, 0, 1, 0, "R7 write to closing bank");
    chk("R6 active until internal pre", bankActive[1], 1);
    nop(1);
    chk("R6 internal pre started", bankActive[1], 0);
    chk("R6 not idle yet", bankIdle[1], 0);
    nop(2);
    chk("R6 still recovering", bankIdle[1], 0);
    nop(1);
    chk("R6 idle after read ap", bankIdle[1], 1);

    // R6 minimum open time dominates
    cfgBurstLen = 4'd1;
    cfgCasLat   = 2'd1;
    doCmd(C_ACT, 0, 0, 1, 1, "R6 act min");
    doCmd(C_RD, 0, 1, 1, 1, "R6 read ap min");
    nop(2);
    chk("R6 held by tRAS min", bankActive[0], 1);
    nop(1);
    chk("R6 pre after tRAS min", bankActive[0], 0);
    nop(2);
    chk("R6 min case recovering", bankIdle[0], 0);
    nop(1);
    chk("R6 min case idle", bankIdle[0], 1);

    // R6 write uses write recovery, not CAS latency
    cfgBurstLen = 4'd2;
    doCmd(C_ACT, 1, 0, 1, 1, "R6 act wr");
    doCmd(C_WR, 1, 1, 1, 1, "R6 write ap");
    nop(3);
    chk("R6 write recovery holds bank", bankActive[1], 1);
    nop(1);
    chk("R6 write internal pre", bankActive[1], 0);
    nop(2);
    chk("R6 write recovering", bankIdle[1], 0);
    nop(1);
    chk("R6 write idle", bankIdle[1], 1);
    cfgCasLat = 2'd2;

    // R4 precharge all
    doCmd(C_ACT, 0, 0, 1, 1, "R4 act b0");
    doCmd(C_ACT, 1, 0, 1, 1, "R4 act b1");
    nop(2);
    doCmd(C_PRE, 0, 1, 1, 0, "R4 pre-all early");
    chk("R2 illegal pre-all ignored", bankActive, 2'b11);
    doCmd(C_PRE, 0, 1, 1, 1, "R4 pre-all");
    nop(2);
    chk("R4 recovering", allIdle, 0);
    nop(1);
    chk("R4 all idle", allIdle, 1);
    chk("R4 bank idle flags", bankIdle, 2'b11);

    // R8 deadline warning
    doCmd(C_ACT, 0, 0, 1, 1, "R8 act");
    nop(33);
    chk("R8 warning not yet", mustPrecharge[0], 0);
    nop(1);
    chk("R8 warning raised", mustPrecharge[0], 1);
    chk("R8 other bank quiet", mustPrecharge[1], 0);
    doCmd(C_PRE, 0, 0, 1, 1, "R8 pre");
    chk("R8 warning cleared", mustPrecharge, 0);
    nop(3);

    // R9 refresh
    doCmd(C_REF, 0, 0, 1, 1, "R9 refresh");
    doCmd(C_ACT, 0, 0, 1, 0, "R9 act during refresh");
    doCmd(C_MRS, 0, 0, 1, 0, "R9 mode set during refresh");
    nop(3);
    chk("R9 busy for tRC", allIdle, 0);
    nop(1);
    chk("R9 idle after tRC", allIdle, 1);
    doCmd(C_MRS, 0, 0, 1, 1, "R9 mode set when idle");

    // R10 cke handling
    doCmd(C_ACT, 0, 0, 1, 1, "R10 act");
    doCmd(C_NOP, 0, 0, 0, 0, "R10 power-down with open bank");
    doCmd(C_ACT, 1, 0, 0, 1, "R10 cke low not decoded");
    chk("R10 command ignored while cke low", bankActive, 2'b01);
    doCmd(C_NOP, 0, 0, 1, 1, "R10 cke rise");
    doCmd(C_PRE, 0, 0, 1, 1, "R10 pre");
    nop(3);
    doCmd(C_NOP, 0, 0, 0, 1, "R10 power-down entry");
    doCmd(C_NOP, 0, 0, 0, 1, "R10 power-down hold");
    doCmd(C_NOP, 0, 0, 1, 1, "R10 power-down exit");
    chk("R10 no busy after power-down", allIdle, 1);

    // R11 self refresh
    doCmd(C_REF, 0, 0, 0, 1, "R11 self refresh entry");
    doCmd(C_NOP, 0, 0, 0, 1, "R11 hold");
    chk("R11 not idle in self refresh", allIdle, 0);
    doCmd(C_NOP, 0, 0, 1, 1, "R11 exit");
    doCmd(C_ACT, 0, 0, 1, 0, "R11 act during exit window");
    nop(4);
    chk("R11 busy after exit", allIdle, 0);
    nop(1);
    chk("R11 idle after exit window", allIdle, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule